// File: doc/BRIEF.md
# Region Boundary Hint Recorder

This per-core block cuts a core's execution into a chain of regions and, at every region boundary, emits a hint record that holds the region's sequence number and the core's running count of memory operations. An offline analysis step uses these hints to split a recorded trace into globally ordered pieces. The state at the end of one region is the starting state of the next, so the counters are never cleared between regions.

Two ways of closing a region are supported, chosen by a mode input. In cycle mode a free-running budget of N clock cycles closes each region, with no traffic to or from other cores. In downgrade mode the block counts coherence downgrade requests seen by the core and closes the region when a configured threshold is reached. The boundary is then announced to the other cores through a one-cycle boundary output, and a boundary announced by another core on the boundary input also closes the local region. Typical settings are a budget of 10,000 cycles or a threshold of 10 or 25 downgrades.

The configuration inputs are assumed to be stable while the block runs. Changing them takes effect from the next cycle.

Top module: `region_hint_recorder`

## Requirements
- R1: While reset is low and in the first cycle after it, `hint_vld_o` and `bnd_req_o` are 0. The first hint after reset carries sequence number 0.
- R2: In cycle mode (`mode_i` = 0) with budget N >= 1, `hint_vld_o` is high for one cycle after every N-th rising clock edge counted from reset release, and is low after every other edge.
- R3: `hint_cnt_o` of a hint equals the total number of cycles with `mem_op_i` high since reset, up to and including the boundary cycle. The count is never cleared at a boundary.
- R4: Each hint's `hint_seq_o` is exactly one more than that of the previous hint.
- R5: In downgrade mode (`mode_i` = 1) with threshold T >= 1, the cycle in which `dngrd_i` brings the downgrade count of the region to T is a boundary. The hint appears after that edge, and `bnd_req_o` is high in the same cycle as that hint.
- R6: After a boundary in downgrade mode the downgrade count restarts at zero, so the next local boundary needs T further downgrades.
- R7: In downgrade mode a cycle with `bnd_req_i` high is a boundary. It emits a hint and restarts the downgrade count, but does not raise `bnd_req_o`.
- R8: In cycle mode `dngrd_i` and `bnd_req_i` have no effect on hint timing, and `bnd_req_o` stays 0.
- R9: A budget of 0 or 1 in cycle mode makes every cycle a boundary.
- R10: A memory operation in the same cycle as a boundary is counted in the region that closes, so it is included in that hint's count.
- R11: In downgrade mode no hint is emitted in cycles without a downgrade that reaches the threshold or an incoming boundary request, however many cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_op_i | input | 1 | One memory operation retired this cycle |
| dngrd_i | input | 1 | One coherence downgrade request seen this cycle |
| mode_i | input | 1 | 0 = cycle-budget mode, 1 = downgrade-count mode |
| cyc_limit_i | input | CYC_W (32) | Cycle budget N per region |
| dg_limit_i | input | DG_W (16) | Downgrade threshold T per region |
| bnd_req_i | input | 1 | Boundary announced by another core (downgrade mode only) |
| bnd_req_o | output | 1 | Boundary announced to other cores, one cycle, with the hint |
| hint_vld_o | output | 1 | Hint record valid this cycle |
| hint_seq_o | output | SEQ_W (16) | Region sequence number of the hint |
| hint_cnt_o | output | CNT_W (32) | Memory-operation count at the boundary |

## Verification
Cycle mode is driven with budgets of 4, 6, 3, 2, 1 and 0 while memory operations, downgrades and incoming requests toggle in unrelated patterns. This separates a budget-driven boundary from one caused by any other input and shows off-by-one errors in the period. Downgrade mode is run with sparse and clustered downgrades, incoming requests in the middle of a partly counted region, and long stretches with no downgrades. These patterns separate local boundaries from remote ones, show whether the count restarts, and show whether the cycle budget leaks into the wrong mode. Putting memory operations exactly on boundary cycles, and only there, tells whether such an operation goes to the closing region or the next one.

// File: rtl/rhr_pkg.sv
// Package: rhr_pkg
// Shared types of the region boundary hint recorder.
// Assumes nothing beyond a 1-bit mode select at the top.
package rhr_pkg;
    typedef enum logic {
        RHR_MODE_CYCLE = 1'b0,
        RHR_MODE_DGRD  = 1'b1
    } rhr_mode_e;
endpackage

// File: rtl/rhr_cycle_bound.sv
// Module: rhr_cycle_bound
// Counts clock cycles within the current region while enabled and fires
// when the cycle budget is used up. A budget of 0 behaves as 1.
// Assumes limit_i is stable while enabled. The counter is held at zero
// when disabled.
module rhr_cycle_bound #(
    parameter int CYC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [CYC_W-1:0] limit_i,
    output logic             fire_o
);
    localparam int EXT_W = CYC_W + 1;

    logic [CYC_W-1:0] cyc_q;
    logic [EXT_W-1:0] cyc_inc;

    // Budget check: this cycle is the last one of the region
    always_comb begin
        cyc_inc = {1'b0, cyc_q} + EXT_W'(1);
        fire_o  = en_i && (cyc_inc >= {1'b0, limit_i});
    end

    // Cycle counter, restarted at each boundary and held while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (!en_i || fire_o) begin
            cyc_q <= '0;
        end else begin
            cyc_q <= cyc_q + CYC_W'(1);
        end
    end

    AST_CYC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        fire_o |=> (cyc_q == '0)); // R2
    AST_CYC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cyc_q == '0)); // R11
endmodule

// File: rtl/rhr_dgrd_bound.sv
// Module: rhr_dgrd_bound
// Counts coherence downgrades within the current region while enabled.
// It closes the region when the threshold is reached (a local boundary)
// or when another core announces a boundary.
// Assumes limit_i is stable while enabled. A threshold of 0 behaves as 1.
module rhr_dgrd_bound #(
    parameter int DG_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic            dg_i,
    input  logic            ext_i,
    input  logic [DG_W-1:0] limit_i,
    output logic            local_o,
    output logic            close_o
);
    localparam int EXT_W = DG_W + 1;

    logic [DG_W-1:0]  dg_q;
    logic [EXT_W-1:0] dg_inc;

    // Threshold check plus remote request merge
    always_comb begin
        dg_inc  = {1'b0, dg_q} + EXT_W'(1);
        local_o = en_i && dg_i && (dg_inc >= {1'b0, limit_i});
        close_o = local_o || (en_i && ext_i);
    end

    // Downgrade counter, restarted at any boundary and held while disabled
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dg_q <= '0;
        end else if (!en_i || close_o) begin
            dg_q <= '0;
        end else if (dg_i) begin
            dg_q <= dg_q + DG_W'(1);
        end
    end

    AST_DG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        close_o |=> (dg_q == '0)); // R6
    AST_DG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (dg_q == '0)); // R8
    AST_DG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !dg_i && !ext_i) |=> $stable(dg_q)); // R11
endmodule

// File: rtl/rhr_hint_emit.sv
// Module: rhr_hint_emit
// Keeps the running memory-operation count and the region sequence
// number, and registers one hint record per boundary. An operation in
// the boundary cycle goes into the closing hint. Neither counter is
// cleared at a boundary.
// Assumes close_i is high whenever local_i is high.
module rhr_hint_emit #(
    parameter int CNT_W = 32,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_op_i,
    input  logic             close_i,
    input  logic             local_i,
    output logic             hint_vld_o,
    output logic [SEQ_W-1:0] hint_seq_o,
    output logic [CNT_W-1:0] hint_cnt_o,
    output logic             bnd_o
);
    logic [CNT_W-1:0] op_q;
    logic [CNT_W-1:0] op_nxt;
    logic [SEQ_W-1:0] seq_q;

    // Operation count including this cycle's operation
    always_comb begin
        op_nxt = op_q + CNT_W'(mem_op_i);
    end

    // Running operation counter across all regions
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q <= '0;
        end else begin
            op_q <= op_nxt;
        end
    end

    // Hint record register and sequence advance at each boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q      <= '0;
            hint_vld_o <= 1'b0;
            hint_seq_o <= '0;
            hint_cnt_o <= '0;
            bnd_o      <= 1'b0;
        end else begin
            hint_vld_o <= close_i;
            bnd_o      <= local_i && close_i;
            if (close_i) begin
                hint_seq_o <= seq_q;
                hint_cnt_o <= op_nxt;
                seq_q      <= seq_q + SEQ_W'(1);
            end
        end
    end

    AST_SEQ_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        hint_vld_o |-> (seq_q == hint_seq_o + SEQ_W'(1))); // R4
    AST_OP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        ((op_q - $past(op_q)) <= CNT_W'(1))); // R3
    AST_HINT_CNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        hint_vld_o |-> (hint_cnt_o == op_q)); // R10
    AST_BND_WITH_HINT: assert property (@(posedge clk) disable iff (!rst_n)
        bnd_o |-> hint_vld_o); // R5
endmodule

// File: rtl/region_hint_recorder.sv
// Module: region_hint_recorder
// Top of the per-core region boundary hint recorder. The mode input picks
// which source closes a region: the cycle budget, or the downgrade
// threshold together with boundary requests from other cores. Each
// boundary yields one registered hint record.
// Assumes the configuration inputs are stable during operation.
module region_hint_recorder
    import rhr_pkg::*;
#(
    parameter int CYC_W = 32,
    parameter int DG_W  = 16,
    parameter int CNT_W = 32,
    parameter int SEQ_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mem_op_i,
    input  logic             dngrd_i,
    input  logic             mode_i,
    input  logic [CYC_W-1:0] cyc_limit_i,
    input  logic [DG_W-1:0]  dg_limit_i,
    input  logic             bnd_req_i,
    output logic             bnd_req_o,
    output logic             hint_vld_o,
    output logic [SEQ_W-1:0] hint_seq_o,
    output logic [CNT_W-1:0] hint_cnt_o
);
    rhr_mode_e mode;
    logic      cyc_en;
    logic      dg_en;
    logic      cyc_fire;
    logic      dg_local;
    logic      dg_close;
    logic      close;

    // Mode decode and boundary merge
    always_comb begin
        mode   = rhr_mode_e'(mode_i);
        cyc_en = (mode == RHR_MODE_CYCLE);
        dg_en  = (mode == RHR_MODE_DGRD);
        close  = cyc_fire || dg_close;
    end

    rhr_cycle_bound #(.CYC_W(CYC_W)) cyc_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (cyc_en),
        .limit_i (cyc_limit_i),
        .fire_o  (cyc_fire)
    );

    rhr_dgrd_bound #(.DG_W(DG_W)) dg_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (dg_en),
        .dg_i    (dngrd_i),
        .ext_i   (bnd_req_i),
        .limit_i (dg_limit_i),
        .local_o (dg_local),
        .close_o (dg_close)
    );

    rhr_hint_emit #(.CNT_W(CNT_W), .SEQ_W(SEQ_W)) emit_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_op_i   (mem_op_i),
        .close_i    (close),
        .local_i    (dg_local),
        .hint_vld_o (hint_vld_o),
        .hint_seq_o (hint_seq_o),
        .hint_cnt_o (hint_cnt_o),
        .bnd_o      (bnd_req_o)
    );

    AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(cyc_fire && dg_close)); // R8
    AST_CYC_NO_BND_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 1'b0) |=> !bnd_req_o); // R8
endmodule

// File: tb/region_hint_recorder_tb_top.sv
`timescale 1ns/1ps
module region_hint_recorder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_op_i = 1'b0;
    logic        dngrd_i = 1'b0;
    logic        mode_i = 1'b0;
    logic [31:0] cyc_limit_i = 32'd4;
    logic [15:0] dg_limit_i = 16'd3;
    logic        bnd_req_i = 1'b0;
    logic        bnd_req_o;
    logic        hint_vld_o;
    logic [15:0] hint_seq_o;
    logic [31:0] hint_cnt_o;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc_total = 0;
    bit done = 1'b0;

    // bench reference state
    int          m_cyc;
    int          m_dg;
    int          m_seq;
    logic [31:0] m_ops;

    always #2.5 clk = ~clk;

    region_hint_recorder dut_i (
        .clk(clk), .rst_n(rst_n), .mem_op_i(mem_op_i), .dngrd_i(dngrd_i),
        .mode_i(mode_i), .cyc_limit_i(cyc_limit_i), .dg_limit_i(dg_limit_i),
        .bnd_req_i(bnd_req_i), .bnd_req_o(bnd_req_o), .hint_vld_o(hint_vld_o),
        .hint_seq_o(hint_seq_o), .hint_cnt_o(hint_cnt_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic do_reset(input bit mode, input int n, input int t);
        mode_i = mode; cyc_limit_i = 32'(n); dg_limit_i = 16'(t);
        mem_op_i = 0; dngrd_i = 0; bnd_req_i = 0;
        rst_n = 0;
        repeat (2) @(negedge clk);
        chk(hint_vld_o == 0, "R1", "hint_vld in reset", hint_vld_o, 0);
        chk(bnd_req_o == 0, "R1", "bnd_req_o in reset", bnd_req_o, 0);
        rst_n = 1;
        m_cyc = 0; m_dg = 0; m_seq = 0; m_ops = 0;
    endtask

    // one cycle: drive, expect from the requirements, sample after the edge
    task automatic tick(input bit mop, input bit dg, input bit br, input string tag);
        bit fire, loc;
        int neff;
        mem_op_i = mop; dngrd_i = dg; bnd_req_i = br;
        m_ops = m_ops + 32'(mop);
        if (mode_i == 1'b0) begin
            m_cyc++;
            neff = (cyc_limit_i < 1) ? 1 : int'(cyc_limit_i);
            fire = ((m_cyc % neff) == 0);
            loc  = 0;
        end else begin
            loc  = dg && ((m_dg + 1) >= int'(dg_limit_i));
            fire = loc || br;
            m_dg = fire ? 0 : m_dg + int'(dg);
        end
        @(posedge clk);
        @(negedge clk);
        chk(hint_vld_o == fire, tag, "hint_vld", hint_vld_o, fire);
        chk(bnd_req_o == loc, tag, "bnd_req_o", bnd_req_o, loc);
        if (fire) begin
            chk(hint_seq_o == 16'(m_seq), tag, "hint_seq", hint_seq_o, m_seq);
            chk(hint_cnt_o == m_ops, tag, "hint_cnt", hint_cnt_o, m_ops);
            m_seq++;
        end
    endtask

    task automatic t_reset_state();
        do_reset(0, 3, 3);
        chk(hint_vld_o == 0, "R1", "hint_vld after release", hint_vld_o, 0);
        tick(1, 0, 0, "R1");
        tick(1, 0, 0, "R1");
        tick(0, 0, 0, "R1"); // first hint, seq 0 expected
    endtask

    task automatic t_cycle_period();
        do_reset(0, 4, 3);
        for (int e = 1; e <= 13; e++) tick(e % 3 != 0, e % 2 == 1, e % 5 == 0, "R2");
    endtask

    task automatic t_cycle_ignores();
        do_reset(0, 6, 1);
        for (int e = 1; e <= 14; e++) tick(e % 2 == 0, 1, 1, "R8");
    endtask

    task automatic t_small_limit();
        do_reset(0, 1, 3);
        for (int e = 1; e <= 5; e++) tick(e % 2 == 0, 0, 0, "R9");
        do_reset(0, 0, 3);
        for (int e = 1; e <= 5; e++) tick(1, 0, 0, "R9");
    endtask

    task automatic t_boundary_op();
        do_reset(0, 3, 3);
        for (int e = 1; e <= 12; e++) tick(e % 3 == 0, 0, 0, "R10");
    endtask

    task automatic t_seq_run();
        do_reset(0, 2, 3);
        for (int e = 1; e <= 40; e++) tick((e * 7) % 5 < 3, 0, 0, "R4");
        chk(m_seq == 20, "R3", "hint total", m_seq, 20);
    endtask

    task automatic t_downgrade();
        do_reset(1, 3, 3);
        for (int e = 1; e <= 24; e++) tick(e % 4 != 1, (e % 3 == 0) || (e > 18), 0, "R5");
        for (int e = 1; e <= 8; e++) tick(1, 1, 0, "R6");
    endtask

    task automatic t_external();
        do_reset(1, 3, 4);
        tick(1, 1, 0, "R7");
        tick(1, 1, 0, "R7");
        tick(1, 0, 1, "R7"); // remote boundary: hint, no bnd_req_o
        for (int e = 1; e <= 4; e++) tick(0, 1, 0, "R6"); // full T again
        tick(1, 0, 1, "R7");
        tick(1, 1, 0, "R7");
        tick(0, 1, 1, "R7"); // remote request with a pending count
        for (int e = 1; e <= 4; e++) tick(1, 1, 0, "R6");
    endtask

    task automatic t_dg_quiet();
        do_reset(1, 2, 2);
        for (int e = 1; e <= 30; e++) tick(e % 2 == 0, 0, 0, "R11");
        tick(1, 1, 0, "R11");
        tick(1, 1, 0, "R11");
    endtask

    always @(posedge clk) begin
        cyc_total++;
        if (cyc_total > 100000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cyc_total);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_cycle_period();
        t_cycle_ignores();
        t_small_limit();
        t_boundary_op();
        t_seq_run();
        t_downgrade();
        t_external();
        t_dg_quiet();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule